// File: doc/BRIEF.md
# Latched Parity Bus Transceiver

This block joins two parallel buses, called A and B, through a set of byte lanes. Each lane carries eight data bits and one parity bit on each bus. All lanes share the same control inputs. Each bus has its own level-sensitive capture stage. The capture stage follows its pins while its enable is high and keeps its contents while the enable is low. Data and parity are always captured together. The active-low drive enables select the direction of transfer. When A drives B, the B side presents the A-side captured data, and B to A works the same way in reverse.

The parity bit sent on the outgoing bus comes from one of two sources. It can be generated from the eight captured data bits, or it can be copied from the incoming parity bit. The sense is selectable, odd or even. Each bus also has a checker that runs all the time and reports through an active-low error flag per lane. Driving both buses at once is illegal. In that case both drivers are switched off and a sticky flag is raised, which only a synchronous reset clears.

Tri-state pins are modelled as separate input, output and output-enable ports. The capture stages are built as clocked registers with a load enable, and a bypass multiplexer selects the live pins while the enable is high. Transparent behaviour is therefore kept, and a closed stage holds the value sampled at the last rising clock edge at which its enable was high.

Top module: `parity_xcvr`

## Requirements
- R1: With `oe_b_n`=0 and `oe_a_n`=1, `b_oe` is 1, `a_oe` is 0, and `b_out` shows the A-side captured data (lane k uses bits [8k+7:8k]).
- R2: With `oe_a_n`=0 and `oe_b_n`=1, `a_oe` is 1, `b_oe` is 0, and `a_out` shows the B-side captured data.
- R3: With both `oe_a_n` and `oe_b_n` at 1, neither `a_oe` nor `b_oe` is asserted.
- R4: With both `oe_a_n` and `oe_b_n` at 0, neither driver is enabled. At the next rising edge `illegal_flag` goes to 1, and it stays at 1 until a rising edge with `rst_n`=0.
- R5: While its enable is high, a capture stage passes its pins through in the same cycle. While the enable is low, the stage holds the data and parity sampled at the last rising edge with the enable high. After reset the held value is zero.
- R6: With `fwd_mode`=0, each outgoing parity bit equals the XOR of the lane's 8 captured source data bits XOR `odd_sel`.
- R7: With `fwd_mode`=1, each outgoing parity bit equals the captured source parity bit of that lane.
- R8: For a bus that is transmitting, idle or in the illegal state, a lane's error flag is 0 exactly when the XOR of that bus's 9 captured bits differs from `odd_sel` (`odd_sel`=0 means even, 1 means odd).
- R9: For the receiving bus with `fwd_mode`=0, every error flag reads 1.
- R10: For the receiving bus with `fwd_mode`=1, a lane's error flag follows the check of the forwarded 9 bits when the receiver's enable is high. It reads 1 when that enable is low.
- R11: Lanes are independent: the parity outputs and error flags of one lane depend only on that lane's bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for capture registers and flag |
| rst_n | input | 1 | Synchronous active-low reset |
| le_a | input | 1 | A-side capture enable, transparent high |
| le_b | input | 1 | B-side capture enable, transparent high |
| oe_a_n | input | 1 | Active-low drive enable of bus A |
| oe_b_n | input | 1 | Active-low drive enable of bus B |
| fwd_mode | input | 1 | 0 generate parity, 1 forward parity |
| odd_sel | input | 1 | 0 even parity, 1 odd parity |
| a_in | input | 16 | A bus data pins (input side) |
| a_par_in | input | 2 | A bus parity pins, one per lane |
| a_out | output | 16 | Data driven onto bus A |
| a_par_out | output | 2 | Parity driven onto bus A |
| a_oe | output | 1 | Bus A driver enable |
| b_in | input | 16 | B bus data pins (input side) |
| b_par_in | input | 2 | B bus parity pins, one per lane |
| b_out | output | 16 | Data driven onto bus B |
| b_par_out | output | 2 | Parity driven onto bus B |
| b_oe | output | 1 | Bus B driver enable |
| err_a_n | output | 2 | Active-low per-lane error of bus A |
| err_b_n | output | 2 | Active-low per-lane error of bus B |
| illegal_flag | output | 1 | Sticky flag for both drivers requested |

## Verification
The data outputs, parity outputs, error flags and driver enables are combinational, so they are valid in the same cycle as the inputs that cause them. The held capture contents and the illegal flag change one rising edge after the stimulus that sets them. The bench applies every stimulus on the falling edge and samples 1 ns later, before the next rising edge. It updates its own held copies and flag model on the rising edge, so every check in a cycle compares against the state produced by the preceding edge.

// File: rtl/parity_xcvr_pkg.sv
package parity_xcvr_pkg;

    typedef enum logic [1:0] {
        DIR_IDLE  = 2'd0,
        DIR_A2B   = 2'd1,
        DIR_B2A   = 2'd2,
        DIR_CLASH = 2'd3
    } xfer_dir_e;

    // Active-low enables: the bus whose enable is low is the one driven.
    function automatic xfer_dir_e decode_dir(input logic oe_a_n, input logic oe_b_n);
        xfer_dir_e d;
        unique case ({oe_a_n, oe_b_n})
            2'b11:   d = DIR_IDLE;
            2'b10:   d = DIR_A2B;
            2'b01:   d = DIR_B2A;
            default: d = DIR_CLASH;
        endcase
        return d;
    endfunction

    typedef struct packed {
        logic clash;
    } ctl_state_t;

endpackage

// File: rtl/parity_tree.sv
module parity_tree #(
    parameter int N = 8
) (
    input  logic [N-1:0] bits,
    output logic         ones_odd
);
    localparam int LV = (N > 1) ? $clog2(N) : 1;
    localparam int PW = 1 << LV;

    logic [PW-1:0] work;

    // Balanced reduction done in place; each level halves the live width.
    always_comb begin
        work = PW'(bits);
        for (int l = 0; l < LV; l++) begin
            for (int i = 0; i < (PW >> (l + 1)); i++) begin
                work[i] = work[2*i] ^ work[2*i+1];
            end
        end
        ones_odd = work[0];
    end
endmodule

// File: rtl/bus_latch.sv
module bus_latch #(
    parameter int LANES = 2,
    parameter int DW    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                le,
    input  logic [LANES*DW-1:0] d_in,
    input  logic [LANES-1:0]    p_in,
    output logic [LANES*DW-1:0] d_view,
    output logic [LANES-1:0]    p_view
);
    localparam int W = LANES * DW;

    typedef struct packed {
        logic [W-1:0]     d;
        logic [LANES-1:0] p;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d = '0;
        end else if (le) begin
            st_d.d = d_in;
            st_d.p = p_in;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // Bypass keeps the stage transparent within the cycle the enable is high.
    assign d_view = le ? d_in : st_q.d;
    assign p_view = le ? p_in : st_q.p;
endmodule

// File: rtl/lane_unit.sv
module lane_unit #(
    parameter int DW = 8
) (
    input  logic          a2b,
    input  logic          b2a,
    input  logic          le_a,
    input  logic          le_b,
    input  logic          fwd_mode,
    input  logic          odd_sel,
    input  logic [DW-1:0] a_d,
    input  logic          a_p,
    input  logic [DW-1:0] b_d,
    input  logic          b_p,
    output logic          a_par_out,
    output logic          b_par_out,
    output logic          err_a_n,
    output logic          err_b_n
);
    logic a_ones, b_ones;
    logic a_ok, b_ok;

    parity_tree #(.N(DW)) u_tree_a (.bits(a_d), .ones_odd(a_ones));
    parity_tree #(.N(DW)) u_tree_b (.bits(b_d), .ones_odd(b_ones));

    always_comb begin
        a_ok = ((a_ones ^ a_p) == odd_sel);
        b_ok = ((b_ones ^ b_p) == odd_sel);

        b_par_out = fwd_mode ? a_p : (a_ones ^ odd_sel);
        a_par_out = fwd_mode ? b_p : (b_ones ^ odd_sel);

        // Receiver reports the forwarded group only when forwarding and open.
        if (b2a) err_a_n = !(fwd_mode && le_a && !b_ok);
        else     err_a_n = a_ok;

        if (a2b) err_b_n = !(fwd_mode && le_b && !a_ok);
        else     err_b_n = b_ok;
    end
endmodule

// File: rtl/parity_xcvr.sv
module parity_xcvr
    import parity_xcvr_pkg::*;
#(
    parameter int LANES = 2,
    parameter int DW    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                le_a,
    input  logic                le_b,
    input  logic                oe_a_n,
    input  logic                oe_b_n,
    input  logic                fwd_mode,
    input  logic                odd_sel,
    input  logic [LANES*DW-1:0] a_in,
    input  logic [LANES-1:0]    a_par_in,
    output logic [LANES*DW-1:0] a_out,
    output logic [LANES-1:0]    a_par_out,
    output logic                a_oe,
    input  logic [LANES*DW-1:0] b_in,
    input  logic [LANES-1:0]    b_par_in,
    output logic [LANES*DW-1:0] b_out,
    output logic [LANES-1:0]    b_par_out,
    output logic                b_oe,
    output logic [LANES-1:0]    err_a_n,
    output logic [LANES-1:0]    err_b_n,
    output logic                illegal_flag
);
    localparam int W = LANES * DW;

    logic [W-1:0]     a_view_d, b_view_d;
    logic [LANES-1:0] a_view_p, b_view_p;
    xfer_dir_e        dir;
    logic             a2b, b2a;
    ctl_state_t       ctl_d, ctl_q;

    bus_latch #(.LANES(LANES), .DW(DW)) u_latch_a (
        .clk(clk), .rst_n(rst_n), .le(le_a),
        .d_in(a_in), .p_in(a_par_in),
        .d_view(a_view_d), .p_view(a_view_p)
    );

    bus_latch #(.LANES(LANES), .DW(DW)) u_latch_b (
        .clk(clk), .rst_n(rst_n), .le(le_b),
        .d_in(b_in), .p_in(b_par_in),
        .d_view(b_view_d), .p_view(b_view_p)
    );

    always_comb begin
        dir = decode_dir(oe_a_n, oe_b_n);
        a2b = (dir == DIR_A2B);
        b2a = (dir == DIR_B2A);
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        lane_unit #(.DW(DW)) u_lane (
            .a2b(a2b), .b2a(b2a),
            .le_a(le_a), .le_b(le_b),
            .fwd_mode(fwd_mode), .odd_sel(odd_sel),
            .a_d(a_view_d[k*DW +: DW]), .a_p(a_view_p[k]),
            .b_d(b_view_d[k*DW +: DW]), .b_p(b_view_p[k]),
            .a_par_out(a_par_out[k]), .b_par_out(b_par_out[k]),
            .err_a_n(err_a_n[k]), .err_b_n(err_b_n[k])
        );
    end

    always_comb begin
        ctl_d = ctl_q;
        if (!rst_n)                 ctl_d.clash = 1'b0;
        else if (dir == DIR_CLASH)  ctl_d.clash = 1'b1;
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

    assign a_out        = b_view_d;
    assign b_out        = a_view_d;
    assign a_oe         = b2a;
    assign b_oe         = a2b;
    assign illegal_flag = ctl_q.clash;
endmodule

// File: rtl/parity_xcvr_chk.sv
module parity_xcvr_chk #(
    parameter int LANES = 2,
    parameter int DW    = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                le_a,
    input logic                le_b,
    input logic                oe_a_n,
    input logic                oe_b_n,
    input logic                fwd_mode,
    input logic                a_oe,
    input logic                b_oe,
    input logic [LANES*DW-1:0] b_out,
    input logic [LANES-1:0]    err_b_n,
    input logic                illegal_flag
);
    // R3
    idle_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_a_n && oe_b_n) |-> (!a_oe && !b_oe));

    // R4
    clash_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_a_n && !oe_b_n) |-> (!a_oe && !b_oe));

    // R4
    clash_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_a_n && !oe_b_n) |=> illegal_flag);

    // R4
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_flag |=> illegal_flag);

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !le_a && !$past(le_a)) |-> $stable(b_out));

    // R9
    rx_gen_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_a_n && !oe_b_n && !fwd_mode) |-> (&err_b_n));

    // R10
    rx_closed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_a_n && !oe_b_n && !le_b) |-> (&err_b_n));
endmodule

bind parity_xcvr parity_xcvr_chk #(.LANES(LANES), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .le_a(le_a), .le_b(le_b),
    .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .fwd_mode(fwd_mode),
    .a_oe(a_oe), .b_oe(b_oe), .b_out(b_out), .err_b_n(err_b_n),
    .illegal_flag(illegal_flag)
);

// File: tb/parity_xcvr_bench.sv
module parity_xcvr_bench;
    localparam int LANES = 2;
    localparam int DW    = 8;
    localparam int W     = LANES * DW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic le_a = 0, le_b = 0, oe_a_n = 1, oe_b_n = 1, fwd_mode = 0, odd_sel = 0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [LANES-1:0] a_par_in = '0, b_par_in = '0;
    logic [W-1:0] a_out, b_out;
    logic [LANES-1:0] a_par_out, b_par_out, err_a_n, err_b_n;
    logic a_oe, b_oe, illegal_flag;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Bench-side model state
    logic [W-1:0] m_ad = '0, m_bd = '0;
    logic [LANES-1:0] m_ap = '0, m_bp = '0;
    logic m_ill = 1'b0;

    always #2 clk = ~clk;

    parity_xcvr #(.LANES(LANES), .DW(DW)) u_parity_xcvr (
        .clk(clk), .rst_n(rst_n), .le_a(le_a), .le_b(le_b),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .fwd_mode(fwd_mode), .odd_sel(odd_sel),
        .a_in(a_in), .a_par_in(a_par_in), .a_out(a_out), .a_par_out(a_par_out), .a_oe(a_oe),
        .b_in(b_in), .b_par_in(b_par_in), .b_out(b_out), .b_par_out(b_par_out), .b_oe(b_oe),
        .err_a_n(err_a_n), .err_b_n(err_b_n), .illegal_flag(illegal_flag)
    );

    function automatic logic ones_odd(input logic [DW-1:0] v);
        logic r = 1'b0;
        for (int i = 0; i < DW; i++) r = r ^ v[i];
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic [W-1:0] vad, vbd;
        logic [LANES-1:0] vap, vbp, ep_a, ep_b, ee_a, ee_b, ok_a, ok_b;
        bit a2b, b2a;
        vad = le_a ? a_in : m_ad;  vap = le_a ? a_par_in : m_ap;
        vbd = le_b ? b_in : m_bd;  vbp = le_b ? b_par_in : m_bp;
        a2b = (!oe_b_n && oe_a_n);
        b2a = (!oe_a_n && oe_b_n);
        for (int k = 0; k < LANES; k++) begin
            ok_a[k] = ((ones_odd(vad[k*DW +: DW]) ^ vap[k]) == odd_sel);
            ok_b[k] = ((ones_odd(vbd[k*DW +: DW]) ^ vbp[k]) == odd_sel);
            ep_b[k] = fwd_mode ? vap[k] : (ones_odd(vad[k*DW +: DW]) ^ odd_sel);
            ep_a[k] = fwd_mode ? vbp[k] : (ones_odd(vbd[k*DW +: DW]) ^ odd_sel);
            ee_a[k] = b2a ? !(fwd_mode && le_a && !ok_b[k]) : ok_a[k];
            ee_b[k] = a2b ? !(fwd_mode && le_b && !ok_a[k]) : ok_b[k];
        end
        chk(le_a ? "R1" : "R5", 64'(b_out), 64'(vad));
        chk(le_b ? "R2" : "R5", 64'(a_out), 64'(vbd));
        if (a2b) begin chk("R1", 64'({a_oe, b_oe}), 64'(2'b01)); end
        else if (b2a) begin chk("R2", 64'({a_oe, b_oe}), 64'(2'b10)); end
        else if (oe_a_n) begin chk("R3", 64'({a_oe, b_oe}), 64'(2'b00)); end
        else begin chk("R4", 64'({a_oe, b_oe}), 64'(2'b00)); end
        chk(fwd_mode ? "R7" : "R6", 64'(b_par_out), 64'(ep_b));
        chk(fwd_mode ? "R7" : "R6", 64'(a_par_out), 64'(ep_a));
        chk(b2a ? (fwd_mode ? "R10" : "R9") : "R8", 64'(err_a_n), 64'(ee_a));
        chk(a2b ? (fwd_mode ? "R10" : "R9") : "R8", 64'(err_b_n), 64'(ee_b));
        chk("R4", 64'(illegal_flag), 64'(m_ill));
    endtask

    task automatic step();
        #1;
        check_all();
        @(posedge clk);
        if (!rst_n) begin
            m_ad = '0; m_ap = '0; m_bd = '0; m_bp = '0; m_ill = 1'b0;
        end else begin
            if (le_a) begin m_ad = a_in; m_ap = a_par_in; end
            if (le_b) begin m_bd = b_in; m_bp = b_par_in; end
            if (!oe_a_n && !oe_b_n) m_ill = 1'b1;
        end
        @(negedge clk);
    endtask

    task automatic rand_data();
        a_in = W'($urandom); b_in = W'($urandom);
        a_par_in = LANES'($urandom); b_par_in = LANES'($urandom);
    endtask

    initial begin
        #800000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        rand_data();
        step(); step();
        // Reset state: held contents zero, flag clear (R5, R4)
        rst_n = 1'b1;
        chk("R5", 64'({b_out, a_out}), 64'(0));
        chk("R4", 64'(illegal_flag), 64'(0));
        step();

        // R5: capture then hold while new data arrives
        le_a = 1; oe_a_n = 1; oe_b_n = 0; a_in = 16'hA55A; a_par_in = 2'b01;
        step();
        le_a = 0; a_in = 16'h0F0F; a_par_in = 2'b10;
        #1 chk("R5", 64'(b_out), 64'(16'hA55A));
        step();

        // R11: lane 0 corrupted, lane 1 valid, even sense, idle check of bus A
        oe_a_n = 1; oe_b_n = 1; fwd_mode = 0; odd_sel = 0; le_a = 1;
        a_in = 16'h0301; a_par_in = 2'b00;
        #1 chk("R11", 64'(err_a_n), 64'(2'b10));
        step();

        // R4: clash sets flag, reset clears it
        oe_a_n = 0; oe_b_n = 0; step();
        oe_a_n = 1; oe_b_n = 1;
        #1 chk("R4", 64'(illegal_flag), 64'(1));
        step();
        rst_n = 0; step();
        rst_n = 1;
        #1 chk("R4", 64'(illegal_flag), 64'(0));
        step();

        // Full sweep of controls
        for (int d = 0; d < 4; d++)
            for (int f = 0; f < 2; f++)
                for (int o = 0; o < 2; o++)
                    for (int l = 0; l < 4; l++) begin
                        {oe_a_n, oe_b_n} = 2'(d);
                        fwd_mode = f[0]; odd_sel = o[0];
                        {le_a, le_b} = 2'(l);
                        rand_data(); step();
                        rand_data(); step();
                    end
        rst_n = 0; step(); rst_n = 1;

        // Random traffic
        for (int n = 0; n < 3000; n++) begin
            rst_n = ($urandom_range(0, 99) != 0);
            {le_a, le_b, fwd_mode, odd_sel} = 4'($urandom);
            {oe_a_n, oe_b_n} = ($urandom_range(0, 19) == 0) ? 2'b00 : 2'($urandom_range(1, 3));
            rand_data();
            step();
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule